// File: doc/BRIEF.md
# Sector Single-Bit ECC Corrector

This block protects one flash sector of up to 512 bytes with a 24-bit single-error-correcting parity code. Bytes stream in one per valid cycle. Each byte is copied into an internal sector buffer at its position in the sector, and it is folded into two 12-bit parity fields. A data bit at byte position `n` and bit position `b` has the 12-bit location `{n[8:0], b[2:0]}`. When such a bit is 1, it toggles that location into the upper field and the bitwise complement of the location into the lower field. The code presented to the outside is the inversion of `{upper, lower}`, so an erased sector of all-0xFF bytes produces a code of all ones. That matches a stored code read back from erased spare bytes.

On the write path, software reads `code_o` after the last byte and stores it next to the data. On the read path, the stored code is presented on `stored_code` and `cmp_go` is pulsed. The block then classifies the XOR difference between the computed code and the stored code. There are four results: clean, a correctable data bit, an error in the code itself, and uncorrectable. For a correctable data bit, the block flips that bit in the sector buffer. Either a compare or a start strobe clears the accumulator, so the block is re-armed for the next sector.

Top module: `ecc_sector_fix`

## Requirements
- R1: After reset, `code_o` is 24'hFFFFFF, `fix_done` is 0, `fix_stat` is 0, and `fix_byte` and `fix_bit` are 0.
- R2: Each accepted byte at sector position n updates the fields as follows. For every 1 bit at position b, the location L = {n[8:0], b[2:0]} is XORed into the upper field and ~L is XORed into the lower field. `code_o` equals ~{upper, lower}, with `code_o[11:0]` holding the inverted lower field. An all-0xFF sector gives 24'hFFFFFF. `code_o` changes only on an accepted byte or a clear.
- R3: `sec_start` clears both fields and the byte position. A `byte_valid` in the same cycle is ignored.
- R4: Bytes that arrive after SECTOR_BYTES bytes have been accepted change neither the code nor the buffer.
- R5: Status encoding is 0 for clean, 1 for data bit corrected, 2 for error in the code only, and 3 for uncorrectable. A zero difference reports 0.
- R6: If the upper 12 bits of the difference XOR the lower 12 bits equal 12'hFFF and difference bits [23:15] are below SECTOR_BYTES, the status is 1. In that case `fix_byte` = difference[23:15] and `fix_bit` = difference[14:12], and that bit of the buffered byte is inverted. For every other status, `fix_byte` and `fix_bit` are 0.
- R7: A complementary difference whose byte field is not below SECTOR_BYTES reports 3 and leaves the buffer unchanged.
- R8: A difference with exactly one bit set reports 2 and leaves the buffer unchanged.
- R9: Any other nonzero difference reports 3.
- R10: The result and a one-cycle `fix_done` pulse appear two clock edges after the edge that samples `cmp_go`. The `cmp_go` edge also clears the accumulator, so `code_o` reads 24'hFFFFFF afterwards.
- R11: Each accepted byte is written to buffer entry n. `buf_rdata` returns the entry at `buf_raddr` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_start | input | 1 | Clear accumulator and byte position |
| byte_valid | input | 1 | `byte_data` carries the next sector byte |
| byte_data | input | 8 | Sector byte |
| code_o | output | 24 | Inverted packed code of the bytes accepted so far |
| stored_code | input | 24 | Code read back from the spare area |
| cmp_go | input | 1 | Compare strobe; also clears the accumulator |
| fix_done | output | 1 | One-cycle pulse, result valid |
| fix_stat | output | 2 | Result class (0 clean, 1 fixed, 2 code error, 3 uncorrectable) |
| fix_byte | output | 9 | Corrected byte index |
| fix_bit | output | 3 | Corrected bit index |
| buf_raddr | input | log2(SECTOR_BYTES) | Buffer read address |
| buf_rdata | output | 8 | Buffer read data, one-cycle latency |

## Verification
A wrong parity field shows at the ports straight away. `code_o` is driven from the field registers, so a bad toggle on any byte is visible one edge after that byte. A fault in the classifier or the location extraction appears on `fix_stat`, `fix_byte` and `fix_bit` two edges after the compare. A fault in the read-modify-write path only appears when the buffer is read back, one edge after the address is presented. The bench therefore reads the buffer after every compare that could have touched a byte.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  localparam int LOC_W  = 12;
  localparam int CODE_W = 2 * LOC_W;
  localparam int BYTE_W = 9;

  typedef enum logic [1:0] {
    ST_CLEAN  = 2'd0,
    ST_FIXED  = 2'd1,
    ST_CODE   = 2'd2,
    ST_UNCORR = 2'd3
  } ecc_stat_e;

  function automatic logic [CODE_W-1:0] pack_code(input logic [LOC_W-1:0] hi,
                                                  input logic [LOC_W-1:0] lo);
    return ~{hi, lo};
  endfunction
endpackage

// File: rtl/ecc_accum.sv
module ecc_accum #(
  parameter int SECTOR_BYTES = 512
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  input  logic                        byte_valid,
  input  logic [7:0]                  byte_data,
  output logic [ecc_fix_pkg::LOC_W-1:0] hi_q,
  output logic [ecc_fix_pkg::LOC_W-1:0] lo_q,
  output logic                        wr_en,
  output logic [$clog2(SECTOR_BYTES)-1:0] wr_addr
);
  import ecc_fix_pkg::*;
  localparam int CW = $clog2(SECTOR_BYTES + 1);
  localparam int AW = $clog2(SECTOR_BYTES);

  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] pos;
  logic [LOC_W-1:0]  tog_hi, tog_lo;
  logic              par;

  assign pos   = BYTE_W'(cnt);
  assign par   = ^byte_data;
  assign wr_en = byte_valid && !clr && (cnt < CW'(SECTOR_BYTES));
  assign wr_addr = cnt[AW-1:0];

  // bit-position fields: parity of the bits whose index has bit k set / clear
  for (genvar k = 0; k < 3; k++) begin : g_bitf
    logic [7:0] sel;
    for (genvar b = 0; b < 8; b++) begin : g_sel
      assign sel[b] = 1'((b >> k) & 1);
    end
    assign tog_hi[k] = ^(byte_data & sel);
    assign tog_lo[k] = ^(byte_data & ~sel);
  end

  // byte-position fields: whole-byte parity gated by the position bit
  for (genvar k = 3; k < LOC_W; k++) begin : g_posf
    assign tog_hi[k] = par & pos[k-3];
    assign tog_lo[k] = par & ~pos[k-3];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hi_q <= '0;
      lo_q <= '0;
      cnt  <= '0;
    end else if (wr_en) begin
      hi_q <= hi_q ^ tog_hi;
      lo_q <= lo_q ^ tog_lo;
      cnt  <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify #(
  parameter int SECTOR_BYTES = 512
) (
  input  logic [ecc_fix_pkg::CODE_W-1:0] calc,
  input  logic [ecc_fix_pkg::CODE_W-1:0] stored,
  output ecc_fix_pkg::ecc_stat_e         stat,
  output logic [ecc_fix_pkg::BYTE_W-1:0] loc_byte,
  output logic [2:0]                     loc_bit
);
  import ecc_fix_pkg::*;
  localparam logic [BYTE_W:0] LIM = (BYTE_W+1)'(SECTOR_BYTES);

  logic [CODE_W-1:0] diff;
  logic              compl;
  assign diff  = calc ^ stored;
  assign compl = ((diff[CODE_W-1:LOC_W] ^ diff[LOC_W-1:0]) == {LOC_W{1'b1}});

  always_comb begin
    stat     = ST_UNCORR;
    loc_byte = '0;
    loc_bit  = '0;
    if (diff == '0) begin
      stat = ST_CLEAN;
    end else if (compl) begin
      if ({1'b0, diff[23:15]} < LIM) begin
        stat     = ST_FIXED;
        loc_byte = diff[23:15];
        loc_bit  = diff[14:12];
      end
    end else if ($onehot(diff)) begin
      stat = ST_CODE;
    end
  end
endmodule

// File: rtl/sector_buf.sv
module sector_buf #(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [7:0]    b_rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/ecc_sector_fix.sv
module ecc_sector_fix #(
  parameter int SECTOR_BYTES = 512,
  localparam int AW = $clog2(SECTOR_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sec_start,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  output logic [23:0]   code_o,
  input  logic [23:0]   stored_code,
  input  logic          cmp_go,
  output logic          fix_done,
  output logic [1:0]    fix_stat,
  output logic [8:0]    fix_byte,
  output logic [2:0]    fix_bit,
  input  logic [AW-1:0] buf_raddr,
  output logic [7:0]    buf_rdata
);
  import ecc_fix_pkg::*;

  logic [LOC_W-1:0] hi_q, lo_q;
  logic             acc_we;
  logic [AW-1:0]    acc_addr;
  ecc_stat_e        cls_stat, s1_stat;
  logic [BYTE_W-1:0] cls_byte, s1_byte;
  logic [2:0]       cls_bit, s1_bit;
  logic             s1_vld;
  logic             a_we;
  logic [AW-1:0]    a_addr;
  logic [7:0]       a_wd, a_rdata;

  ecc_accum #(.SECTOR_BYTES(SECTOR_BYTES)) u_acc (
    .clk(clk), .rst(rst), .clr(sec_start | cmp_go),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .hi_q(hi_q), .lo_q(lo_q), .wr_en(acc_we), .wr_addr(acc_addr)
  );

  assign code_o = pack_code(hi_q, lo_q);

  ecc_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
    .calc(code_o), .stored(stored_code),
    .stat(cls_stat), .loc_byte(cls_byte), .loc_bit(cls_bit)
  );

  // port A: fix write > compare read > stream write
  always_comb begin
    if (s1_vld && s1_stat == ST_FIXED) begin
      a_we   = 1'b1;
      a_addr = s1_byte[AW-1:0];
      a_wd   = a_rdata ^ (8'b1 << s1_bit);
    end else if (cmp_go) begin
      a_we   = 1'b0;
      a_addr = cls_byte[AW-1:0];
      a_wd   = byte_data;
    end else begin
      a_we   = acc_we;
      a_addr = acc_addr;
      a_wd   = byte_data;
    end
  end

  sector_buf #(.DEPTH(SECTOR_BYTES)) u_buf (
    .clk(clk), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wd), .a_rdata(a_rdata),
    .b_addr(buf_raddr), .b_rdata(buf_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_stat <= ST_CLEAN;
      s1_byte <= '0;
      s1_bit  <= '0;
    end else begin
      s1_vld <= cmp_go;
      if (cmp_go) begin
        s1_stat <= cls_stat;
        s1_byte <= cls_byte;
        s1_bit  <= cls_bit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fix_done <= 1'b0;
      fix_stat <= 2'd0;
      fix_byte <= '0;
      fix_bit  <= '0;
    end else begin
      fix_done <= s1_vld;
      if (s1_vld) begin
        fix_stat <= s1_stat;
        fix_byte <= s1_byte;
        fix_bit  <= s1_bit;
      end
    end
  end
endmodule

// File: rtl/ecc_sector_fix_chk.sv
module ecc_sector_fix_chk #(
  parameter int SECTOR_BYTES = 512
) (
  input logic        clk,
  input logic        rst,
  input logic        sec_start,
  input logic        byte_valid,
  input logic        cmp_go,
  input logic [23:0] code_o,
  input logic        fix_done,
  input logic [1:0]  fix_stat,
  input logic [8:0]  fix_byte,
  input logic [2:0]  fix_bit
);
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    (sec_start || cmp_go) |=> code_o == 24'hFFFFFF);

  a_r10_done_latency: assert property (@(posedge clk) disable iff (rst)
    cmp_go |=> ##1 fix_done);

  a_r7_fix_in_range: assert property (@(posedge clk) disable iff (rst)
    (fix_done && fix_stat == 2'd1) |-> 32'(fix_byte) < SECTOR_BYTES);

  a_r6_loc_cleared: assert property (@(posedge clk) disable iff (rst)
    (fix_done && fix_stat != 2'd1) |-> (fix_byte == 9'd0 && fix_bit == 3'd0));

  a_r2_code_hold: assert property (@(posedge clk) disable iff (rst)
    (!sec_start && !byte_valid && !cmp_go) |=> $stable(code_o));
endmodule

bind ecc_sector_fix ecc_sector_fix_chk #(.SECTOR_BYTES(SECTOR_BYTES)) u_chk (
  .clk(clk), .rst(rst), .sec_start(sec_start), .byte_valid(byte_valid),
  .cmp_go(cmp_go), .code_o(code_o), .fix_done(fix_done), .fix_stat(fix_stat),
  .fix_byte(fix_byte), .fix_bit(fix_bit)
);

// File: tb/ecc_sector_fix_bench.sv
module ecc_sector_fix_bench;
  localparam int SEC = 256;
  localparam int AW  = $clog2(SEC);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sec_start = 1'b0, byte_valid = 1'b0, cmp_go = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [23:0] stored_code = '0, code_o;
  logic fix_done;
  logic [1:0] fix_stat;
  logic [8:0] fix_byte;
  logic [2:0] fix_bit;
  logic [AW-1:0] buf_raddr = '0;
  logic [7:0] buf_rdata;

  int n_chk = 0, n_fail = 0;
  logic [7:0] img [SEC];
  logic [13:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  ecc_sector_fix #(.SECTOR_BYTES(SEC)) u_ecc_sector_fix (
    .clk(clk), .rst(rst), .sec_start(sec_start), .byte_valid(byte_valid),
    .byte_data(byte_data), .code_o(code_o), .stored_code(stored_code),
    .cmp_go(cmp_go), .fix_done(fix_done), .fix_stat(fix_stat),
    .fix_byte(fix_byte), .fix_bit(fix_bit), .buf_raddr(buf_raddr),
    .buf_rdata(buf_rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-bit reference: every set bit contributes its location and its complement
  function automatic logic [23:0] model(int n);
    logic [11:0] hi = '0, lo = '0, loc;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        if (img[i][b]) begin
          loc = {9'(i), 3'(b)};
          hi ^= loc;
          lo ^= ~loc;
        end
    return ~{hi, lo};
  endfunction

  task automatic push_byte(logic [7:0] d);
    byte_valid = 1'b1; byte_data = d;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic restart();
    sec_start = 1'b1;
    @(negedge clk);
    sec_start = 1'b0;
  endtask

  task automatic stream_img();
    restart();
    for (int i = 0; i < SEC; i++) push_byte(img[i]);
  endtask

  task automatic read_buf(int a, output logic [7:0] d);
    buf_raddr = AW'(a);
    @(negedge clk);
    d = buf_rdata;
  endtask

  // driver: push the expected result, then strobe the compare
  task automatic compare(string tag, logic [23:0] st, logic [1:0] es,
                         logic [8:0] eb, logic [2:0] ei);
    exp_q.push_back({es, eb, ei});
    tag_q.push_back(tag);
    stored_code = st; cmp_go = 1'b1;
    @(negedge clk);
    cmp_go = 1'b0;
    check("R10 code cleared by compare", 32'(code_o), 32'hFFFFFF);
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pop and compare on every done pulse
  always @(negedge clk) begin
    if (!rst && fix_done) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected done", 32'(fix_done), 32'd0);
      end else begin
        logic [13:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 32'({fix_stat, fix_byte, fix_bit}), 32'(e));
      end
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [23:0] g, d24;
    logic [7:0] rd;
    logic [11:0] loc;
    for (int i = 0; i < SEC; i++) img[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 reset code", 32'(code_o), 32'hFFFFFF);
    check("R1 reset done/stat/loc", 32'({fix_done, fix_stat, fix_byte, fix_bit}), 32'd0);

    // R2 erased sector
    restart();
    for (int i = 0; i < SEC; i++) push_byte(8'hFF);
    check("R2 erased code", 32'(code_o), 32'hFFFFFF);

    // R2, R11 pattern sector
    stream_img();
    g = model(SEC);
    check("R2 pattern code", 32'(code_o), 32'(g));
    read_buf(0, rd);   check("R11 buffer entry 0", 32'(rd), 32'(img[0]));
    read_buf(200, rd); check("R11 buffer entry 200", 32'(rd), 32'(img[200]));

    // R5 clean
    compare("R5 clean", g, 2'd0, 9'd0, 3'd0);

    // R6 single data-bit error at byte 77 bit 5
    restart();
    for (int i = 0; i < SEC; i++) push_byte(i == 77 ? img[i] ^ 8'h20 : img[i]);
    compare("R6 corrected location", g, 2'd1, 9'd77, 3'd5);
    read_buf(77, rd); check("R6 buffer bit restored", 32'(rd), 32'(img[77]));

    // R8 code-only error
    stream_img();
    compare("R8 code-only error", g ^ 24'h000200, 2'd2, 9'd0, 3'd0);
    read_buf(9, rd); check("R8 buffer unchanged", 32'(rd), 32'(img[9]));

    // R9 multi-bit
    stream_img();
    compare("R9 uncorrectable", g ^ 24'h000007, 2'd3, 9'd0, 3'd0);

    // R7 complementary but byte index 300 out of range
    stream_img();
    loc = {9'd300, 3'd2};
    d24 = {loc, ~loc};
    compare("R7 out-of-range", g ^ d24, 2'd3, 9'd0, 3'd0);
    read_buf(44, rd); check("R7 buffer unchanged", 32'(rd), 32'(img[44]));

    // R3 start with a colliding byte
    restart();
    for (int i = 0; i < 5; i++) push_byte(8'h55);
    sec_start = 1'b1; byte_valid = 1'b1; byte_data = 8'hFF;
    @(negedge clk);
    sec_start = 1'b0; byte_valid = 1'b0;
    check("R3 start clears, byte ignored", 32'(code_o), 32'hFFFFFF);
    push_byte(8'h01);
    check("R3 position restarts at 0", 32'(code_o), 32'hFFF000);
    read_buf(0, rd); check("R3 buffer entry 0", 32'(rd), 32'h01);

    // R4 bytes past the sector end
    stream_img();
    for (int i = 0; i < 3; i++) push_byte(8'hAB);
    check("R4 extra bytes ignored", 32'(code_o), 32'(g));
    read_buf(0, rd); check("R4 buffer untouched", 32'(rd), 32'(img[0]));

    repeat (3) @(negedge clk);
    check("R10 all results seen", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule